// File: doc/BRIEF.md
# Vector Strip Sequencer

The block splits a one-dimensional elementwise loop over N elements into strips that fit a vector register of at most 64 elements. A job is requested with a one-cycle `start` pulse that carries the element count and three byte base addresses: two source arrays and one destination array. The block then issues strip commands one at a time over a valid/ready handshake. Each command gives the strip's vector length and the three current pointers.

The odd-sized part of the job goes first. The first strip holds N mod 64 elements, and every later strip holds 64. When N is an exact multiple of 64 no empty strip is issued, so the first strip is a full one. After each accepted strip, every pointer moves forward by the strip length times 8 bytes, and the remaining count drops by the same length.

When the last strip has been accepted, `done` pulses for one cycle. A job with N equal to zero issues no strip and pulses `done` one cycle after `start`. The block only sequences the strips. The loads, the arithmetic and the stores are done downstream.

Top module: `strip_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `strip_valid` and `done` are 0.
- R2: A `start` taken while no job is active, with N > 0 and N mod 64 nonzero, makes `strip_valid` go high on the next cycle. That first command has `strip_len` = N mod 64 and pointers equal to the three base addresses.
- R3: When N > 0 and N mod 64 = 0, the first strip has `strip_len` = 64 and no strip of length 0 is issued.
- R4: Every strip after the first in a job has `strip_len` = 64.
- R5: In the cycle after a strip is accepted (`strip_valid` and `strip_ready` both high at a clock edge), each of the three pointers equals its earlier value plus `strip_len` × 8, modulo 2^32, for as long as the job continues.
- R6: The lengths of the strips accepted in one job add up to N. In the cycle after the final strip is accepted, `strip_valid` is 0 and `done` is 1 for exactly one cycle.
- R7: A `start` with N = 0 issues no strip, and `done` is 1 in the next cycle only.
- R8: While `strip_valid` is 1 and `strip_ready` is 0, the command stays valid and `strip_len` and all three pointers stay unchanged.
- R9: A `start` pulse while a job is active, meaning from the first strip being presented until the final acceptance, is ignored. The current job's lengths, pointers and strip count do not change, and no second job follows.
- R10: Whenever `strip_valid` is 1, `strip_len` lies between 1 and 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle job request, taken only when no job is active |
| total_n | input | 32 | Unsigned element count of the job, sampled with `start` |
| base_a | input | 32 | Byte base address of the first source array |
| base_b | input | 32 | Byte base address of the second source array |
| base_c | input | 32 | Byte base address of the destination array |
| strip_ready | input | 1 | Consumer accepts the current strip command |
| strip_valid | output | 1 | A strip command is presented |
| strip_len | output | 7 | Vector length of the current strip, 1 to 64 |
| strip_ptr_a | output | 32 | Current pointer into the first source array |
| strip_ptr_b | output | 32 | Current pointer into the second source array |
| strip_ptr_c | output | 32 | Current pointer into the destination array |
| done | output | 1 | One-cycle pulse after the job's last strip is accepted, or after a zero-count start |

## Verification
Five kinds of job are run:
- **Zero count.** Shows that the empty case finishes at once and issues no strip.
- **Short count (5, 1).** Shows a lone remainder strip.
- **Exact multiples (64, 128).** Shows that a zero-length remainder strip is skipped rather than issued.
- **Mixed counts (130, 200).** Separate the remainder-first ordering from a full-strips-first ordering, because the pointer sequences differ.
- **Base near the top of the address range.** Shows that pointer advance wraps modulo 2^32.

The consumer side is driven three ways: always ready, alternating, and pseudo-random stalls. Comparing these shows whether commands hold still under back-pressure and advance only on acceptance. A second `start` with different values, pulsed mid-job, shows whether a request during an active job leaks into the running strip sequence.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_state_t;
endpackage

// File: rtl/strip_first_len.sv
module strip_first_len #(
  parameter int CNT_W = 32,
  parameter int MAXVL = 64,
  parameter int LEN_W = $clog2(MAXVL) + 1
) (
  input  logic [CNT_W-1:0] count,
  output logic [LEN_W-1:0] first_len
);
  localparam int MOD_W = $clog2(MAXVL);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(MAXVL);

  logic [MOD_W-1:0] remainder;

  // MAXVL is a power of two, so the remainder is the low bits of the count.
  assign remainder = count[MOD_W-1:0];

  always_comb begin
    if (remainder == '0) first_len = FULL;
    else                 first_len = {{(LEN_W-MOD_W){1'b0}}, remainder};
  end
endmodule

// File: rtl/strip_ptr_bank.sv
module strip_ptr_bank #(
  parameter int ADDR_W = 32,
  parameter int NPTR   = 3,
  parameter int LEN_W  = 7,
  parameter int SHIFT  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic                        advance,
  input  logic [NPTR-1:0][ADDR_W-1:0] bases,
  input  logic [LEN_W-1:0]            len,
  output logic [NPTR-1:0][ADDR_W-1:0] ptrs
);
  logic [ADDR_W-1:0] step;

  // Byte distance covered by one strip: len elements of 2^SHIFT bytes each.
  assign step = {{(ADDR_W-LEN_W){1'b0}}, len} << SHIFT;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)          ptrs[g] <= '0;
      else if (load)    ptrs[g] <= bases[g];
      else if (advance) ptrs[g] <= ptrs[g] + step;
    end
  end
endmodule

// File: rtl/strip_ctrl.sv
module strip_ctrl
  import strip_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int MAXVL = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] total_n,
  input  logic [LEN_W-1:0] first_len,
  input  logic             ready,
  output logic             valid,
  output logic [LEN_W-1:0] len,
  output logic             done,
  output logic             load,
  output logic             advance
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(MAXVL);

  seq_state_t       state;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] rem_after;
  logic             take;

  assign take      = start && (state == SEQ_IDLE);
  assign load      = take && (total_n != '0);
  assign advance   = valid && ready;
  assign rem_after = remaining - {{(CNT_W-LEN_W){1'b0}}, len};
  assign valid     = (state == SEQ_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      remaining <= '0;
      len       <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (take) begin
            if (total_n == '0) begin
              done <= 1'b1;
            end else begin
              state     <= SEQ_ISSUE;
              remaining <= total_n;
              len       <= first_len;
            end
          end
        end
        SEQ_ISSUE: begin
          if (advance) begin
            remaining <= rem_after;
            if (rem_after == '0) begin
              state <= SEQ_IDLE;
              done  <= 1'b1;
            end else begin
              len <= FULL;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int MAXVL      = 64,
  parameter int ELEM_BYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [CNT_W-1:0]           total_n,
  input  logic [ADDR_W-1:0]          base_a,
  input  logic [ADDR_W-1:0]          base_b,
  input  logic [ADDR_W-1:0]          base_c,
  input  logic                       strip_ready,
  output logic                       strip_valid,
  output logic [$clog2(MAXVL):0]     strip_len,
  output logic [ADDR_W-1:0]          strip_ptr_a,
  output logic [ADDR_W-1:0]          strip_ptr_b,
  output logic [ADDR_W-1:0]          strip_ptr_c,
  output logic                       done
);
  localparam int LEN_W = $clog2(MAXVL) + 1;
  localparam int SHIFT = $clog2(ELEM_BYTES);
  localparam int NPTR  = 3;

  logic [LEN_W-1:0]            first_len;
  logic                        load;
  logic                        advance;
  logic [NPTR-1:0][ADDR_W-1:0] bases;
  logic [NPTR-1:0][ADDR_W-1:0] ptrs;

  assign bases[0] = base_a;
  assign bases[1] = base_b;
  assign bases[2] = base_c;

  strip_first_len #(
    .CNT_W(CNT_W), .MAXVL(MAXVL), .LEN_W(LEN_W)
  ) u_first (
    .count     (total_n),
    .first_len (first_len)
  );

  strip_ctrl #(
    .CNT_W(CNT_W), .MAXVL(MAXVL), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .total_n   (total_n),
    .first_len (first_len),
    .ready     (strip_ready),
    .valid     (strip_valid),
    .len       (strip_len),
    .done      (done),
    .load      (load),
    .advance   (advance)
  );

  strip_ptr_bank #(
    .ADDR_W(ADDR_W), .NPTR(NPTR), .LEN_W(LEN_W), .SHIFT(SHIFT)
  ) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .advance (advance),
    .bases   (bases),
    .len     (strip_len),
    .ptrs    (ptrs)
  );

  assign strip_ptr_a = ptrs[0];
  assign strip_ptr_b = ptrs[1];
  assign strip_ptr_c = ptrs[2];
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int MAXVL      = 64,
  parameter int ELEM_BYTES = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   strip_ready,
  input logic                   strip_valid,
  input logic [$clog2(MAXVL):0] strip_len,
  input logic [ADDR_W-1:0]      strip_ptr_a,
  input logic [ADDR_W-1:0]      strip_ptr_b,
  input logic [ADDR_W-1:0]      strip_ptr_c,
  input logic                   done
);
  localparam int LEN_W = $clog2(MAXVL) + 1;
  localparam int SHIFT = $clog2(ELEM_BYTES);

  function automatic logic [ADDR_W-1:0] stepof(input logic [LEN_W-1:0] l);
    return {{(ADDR_W-LEN_W){1'b0}}, l} << SHIFT;
  endfunction

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (strip_valid && !strip_ready) |=> (strip_valid && $stable(strip_len) &&
      $stable(strip_ptr_a) && $stable(strip_ptr_b) && $stable(strip_ptr_c)));

  p_len_range_r10: assert property (@(posedge clk) disable iff (rst)
    strip_valid |-> (strip_len != '0 && strip_len <= LEN_W'(MAXVL)));

  p_later_full_r4: assert property (@(posedge clk) disable iff (rst)
    (strip_valid && strip_ready) |=> (!strip_valid || strip_len == LEN_W'(MAXVL)));

  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (strip_valid && strip_ready) |=> (!strip_valid ||
      (strip_ptr_a == $past(strip_ptr_a) + stepof($past(strip_len)) &&
       strip_ptr_b == $past(strip_ptr_b) + stepof($past(strip_len)) &&
       strip_ptr_c == $past(strip_ptr_c) + stepof($past(strip_len)))));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !strip_valid);
endmodule

bind strip_seq strip_seq_chk #(
  .ADDR_W(ADDR_W), .MAXVL(MAXVL), .ELEM_BYTES(ELEM_BYTES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .strip_ready (strip_ready),
  .strip_valid (strip_valid),
  .strip_len   (strip_len),
  .strip_ptr_a (strip_ptr_a),
  .strip_ptr_b (strip_ptr_b),
  .strip_ptr_c (strip_ptr_c),
  .done        (done)
);

// File: tb/tb_strip_seq.sv
`timescale 1ns/1ps
module tb_strip_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] total_n = '0;
  logic [31:0] base_a = '0, base_b = '0, base_c = '0;
  logic        strip_ready = 1'b0;
  logic        strip_valid;
  logic [6:0]  strip_len;
  logic [31:0] strip_ptr_a, strip_ptr_b, strip_ptr_c;
  logic        done;

  always #4 clk = ~clk;

  strip_seq dut (
    .clk(clk), .rst(rst), .start(start), .total_n(total_n),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .strip_ready(strip_ready), .strip_valid(strip_valid),
    .strip_len(strip_len), .strip_ptr_a(strip_ptr_a),
    .strip_ptr_b(strip_ptr_b), .strip_ptr_c(strip_ptr_c), .done(done)
  );

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Behavioural reference: expected outputs after each edge.
  bit          m_valid = 0, m_done = 0, m_first = 0;
  int          m_len = 0;
  longint      m_rem = 0;
  logic [31:0] m_pa = 0, m_pb = 0, m_pc = 0;
  longint      job_n = 0, job_sum = 0;
  int          job_strips = 0;

  always @(posedge clk) begin
    m_done = 0;
    if (rst) begin
      m_valid = 0;
    end else if (m_valid) begin
      if (strip_ready) begin
        m_pa = m_pa + 32'(m_len * 8);
        m_pb = m_pb + 32'(m_len * 8);
        m_pc = m_pc + 32'(m_len * 8);
        m_rem = m_rem - m_len;
        m_first = 0;
        if (m_rem == 0) begin m_valid = 0; m_done = 1; end
        else m_len = 64;
      end
    end else if (start) begin
      job_n = total_n; job_sum = 0; job_strips = 0;
      if (total_n == 0) m_done = 1;
      else begin
        m_valid = 1; m_first = 1; m_rem = total_n;
        m_len = (total_n % 64 == 0) ? 64 : int'(total_n % 64);
        m_pa = base_a; m_pb = base_b; m_pc = base_c;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare at the falling edge, away from the active edge.
  always @(negedge clk) begin
    chk(tag, "strip_valid", strip_valid, m_valid);
    chk(m_done ? "R6" : tag, "done", done, m_done);
    if (m_valid && strip_valid) begin
      chk(m_first ? (job_n % 64 == 0 ? "R3" : "R2") : "R4", "strip_len", strip_len, m_len);
      chk("R5", "ptr_a", strip_ptr_a, m_pa);
      chk("R5", "ptr_b", strip_ptr_b, m_pb);
      chk("R5", "ptr_c", strip_ptr_c, m_pc);
      chk("R10", "len in range", (strip_len >= 1 && strip_len <= 64), 1);
      if (strip_ready) begin job_sum += strip_len; job_strips++; end
    end
    if (m_done && done) begin
      chk(job_n == 0 ? "R7" : "R6", "sum of strip lengths", job_sum, job_n);
      chk(job_n == 0 ? "R7" : "R9", "strip count", job_strips,
          (job_n == 0) ? 0 : (job_n + 63) / 64);
    end
  end

  // Consumer ready driver.
  initial begin
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
        0: strip_ready = 1'b1;
        1: strip_ready = ~strip_ready;
        default: strip_ready = lfsr[0] & lfsr[3];
      endcase
    end
  end

  task automatic run_job(input string t, input longint n, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c, input bit poke);
    @(posedge clk); #2;
    tag = t;
    total_n = 32'(n); base_a = a; base_b = b; base_c = c; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0; total_n = '0; base_a = '0; base_b = '0; base_c = '0;
    if (poke && n > 64) begin
      repeat (3) @(posedge clk);
      #2; tag = "R9";
      total_n = 32'd7; base_a = 32'h5555_0000; base_b = 32'h6666_0000;
      base_c = 32'h7777_0000; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0; total_n = '0;
    end
    while (!(m_done || (!m_valid && n == 0))) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL R6 watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    tag = "R1";
    repeat (4) @(posedge clk);
    #2; rst = 1'b0;
    repeat (2) @(posedge clk);
    ready_mode = 0;
    run_job("R7", 0,   32'h1000, 32'h2000, 32'h3000, 0);
    run_job("R2", 5,   32'h1000, 32'h2000, 32'h3000, 0);
    run_job("R3", 64,  32'h0100, 32'h0200, 32'h0300, 0);
    run_job("R3", 128, 32'h4000, 32'h8000, 32'hC000, 0);
    run_job("R4", 130, 32'h1000, 32'h2000, 32'h3000, 0);
    ready_mode = 1;
    run_job("R8", 200, 32'hA000, 32'hB000, 32'hC000, 1);
    run_job("R2", 1,   32'h10,   32'h20,   32'h30,   0);
    ready_mode = 2;
    run_job("R8", 300, 32'h2000, 32'h6000, 32'h9000, 1);
    run_job("R5", 70,  32'hFFFF_FF00, 32'hFFFF_FFF8, 32'h0, 0);
    run_job("R7", 0,   32'h1, 32'h2, 32'h3, 0);
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule